// File: doc/BRIEF.md
# Open-Drain Pin-Pair Control Register

This block is a single 32-bit control word that lets software bit-bang a two-wire serial link (a clock pin and a data pin) through open-drain pads. Each pin owns a direction bit, a stored output-value bit, a read-only sampled-input bit and a pull-up-disable bit. The direction bit and the value bit each have a write-enable (mask) bit beside them, so one register write can move the clock pin without disturbing the data pin, or the reverse.

The pads are open-drain. A pin the block lets go floats high through its external pull-up. A pin it drives is always pulled low. The pad enable is asserted only when the direction bit says output and the stored value is 0. The stored value therefore survives while the pin is released, and a later write that changes only the direction puts the remembered level back on the wire. Pad inputs are brought into the clock domain through a synchroniser before they are read back.

The pull-up-disable bits carry no mask and are loaded on every accepted write, so software must read them and write them back each time. Reads are combinational from the register state.

Top module: `gpio_pin_reg`

## Requirements
- R1: During and right after reset, both pins are released (direction = input), both stored values and both pull-up-disable bits are 0, both pad enables are low, and the whole readback word is 0.
- R2: The direction bit (clock bit 0, data bit 8; 1 = output) takes the written value only in a write whose direction-mask bit (clock bit 1, data bit 9) is 1. Otherwise it keeps its value.
- R3: The stored value bit (clock bit 2, data bit 10) takes the written value only in a write whose value-mask bit (clock bit 3, data bit 11) is 1. Otherwise it keeps its value.
- R4: A write whose mask bits cover only one pin leaves the other pin's direction, value and pad enable unchanged.
- R5: A pin's pad enable is high exactly when its direction is output and its stored value is 0. Both pad output levels are always 0.
- R6: The input bit (clock bit 4, data bit 12) shows the pad level through two flops. A pad change made between edges appears in the readback after the second rising edge and not after the first.
- R7: The mask bits (1, 3, 9, 11) and all bits outside the defined fields read back as 0. Setting any undefined bit in a write has no effect.
- R8: The pull-up-disable bits (clock bit 5, data bit 13) are loaded from every accepted write, whatever the mask bits are, and drive the pull-up-disable outputs.
- R9: A pin's stored value is kept while the pin is released. A later direction-only write to output enables the pad only if that stored value is 0.
- R10: When the write strobe is low, the write data has no effect on any field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data, including the mask bits |
| rdData | output | 32 | Readback of the control word |
| sclIn | input | 1 | Clock pad input level |
| sdaIn | input | 1 | Data pad input level |
| sclOe | output | 1 | Clock pad enable (pulls the pin low when high) |
| sclOut | output | 1 | Clock pad output level, always 0 |
| sdaOe | output | 1 | Data pad enable (pulls the pin low when high) |
| sdaOut | output | 1 | Data pad output level, always 0 |
| sclPullupDis | output | 1 | Disables the clock pin pull-up |
| sdaPullupDis | output | 1 | Disables the data pin pull-up |

## Verification
The hardest state to reach is a pin that is released while it holds a stored value of 1 and then switched to output by a direction-only write, since neither step alone changes the pad. The stimulus table gets there by first writing only the value field with its mask while the pin is an input, then writing only the direction field. It then checks that the pad enable stays low until a separate value write clears the stored bit. The synchroniser latency is checked by changing a pad level between edges and reading the input bit after one edge and again after two.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int PIN_COUNT    = 2;
  localparam int FIELD_STRIDE = 8;
  localparam int DIR_BIT      = 0;
  localparam int DIR_MASK_BIT = 1;
  localparam int VAL_BIT      = 2;
  localparam int VAL_MASK_BIT = 3;
  localparam int IN_BIT       = 4;
  localparam int PUD_BIT      = 5;

  typedef struct packed {
    logic dirWr;
    logic dirVal;
    logic valWr;
    logic valVal;
    logic pudWr;
    logic pudVal;
  } pinStrobe_t;
endpackage

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                                 wrEn,
  input  logic [DATA_W-1:0]                    wrData,
  output pinStrobe_t [PIN_COUNT-1:0]           strobes
);
  function automatic logic [DATA_W-1:0] usedBits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      m[p*FIELD_STRIDE + DIR_BIT]      = 1'b1;
      m[p*FIELD_STRIDE + DIR_MASK_BIT] = 1'b1;
      m[p*FIELD_STRIDE + VAL_BIT]      = 1'b1;
      m[p*FIELD_STRIDE + VAL_MASK_BIT] = 1'b1;
      m[p*FIELD_STRIDE + PUD_BIT]      = 1'b1;
    end
    return m;
  endfunction

  localparam logic [DATA_W-1:0] USED_MASK = usedBits();

  logic unusedBits;
  assign unusedBits = ^(wrData & ~USED_MASK);

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    localparam int BASE = p * FIELD_STRIDE;
    always_comb begin
      strobes[p].dirWr  = wrEn & wrData[BASE + DIR_MASK_BIT];
      strobes[p].dirVal = wrData[BASE + DIR_BIT];
      strobes[p].valWr  = wrEn & wrData[BASE + VAL_MASK_BIT];
      strobes[p].valVal = wrData[BASE + VAL_BIT];
      strobes[p].pudWr  = wrEn;
      strobes[p].pudVal = wrData[BASE + PUD_BIT];
    end
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic padIn,
  output logic syncOut
);
  if (SYNC_STAGES <= 1) begin : g_single
    logic stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= 1'b0;
      else       stageQ <= padIn;
    end
    assign syncOut = stageQ;
  end else begin : g_chain
    logic [SYNC_STAGES-1:0] stageQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ <= '0;
      else       stageQ <= {stageQ[SYNC_STAGES-2:0], padIn};
    end
    assign syncOut = stageQ[SYNC_STAGES-1];
  end
endmodule

// File: rtl/gpio_pin_datapath.sv
module gpio_pin_datapath
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pinStrobe_t [PIN_COUNT-1:0] strobes,
  input  logic [PIN_COUNT-1:0]       padIn,
  output logic [PIN_COUNT-1:0]       padOe,
  output logic [PIN_COUNT-1:0]       padOut,
  output logic [PIN_COUNT-1:0]       pudOut,
  output logic [DATA_W-1:0]          rdData
);
  logic [PIN_COUNT-1:0] dirQ;
  logic [PIN_COUNT-1:0] valQ;
  logic [PIN_COUNT-1:0] pudQ;
  logic [PIN_COUNT-1:0] inSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '0;
      valQ <= '0;
      pudQ <= '0;
    end else begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (strobes[p].dirWr) dirQ[p] <= strobes[p].dirVal;
        if (strobes[p].valWr) valQ[p] <= strobes[p].valVal;
        if (strobes[p].pudWr) pudQ[p] <= strobes[p].pudVal;
      end
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_sync
    gpio_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .padIn   (padIn[p]),
      .syncOut (inSync[p])
    );
  end

  assign padOe  = dirQ & ~valQ;
  assign padOut = '0;
  assign pudOut = pudQ;

  always_comb begin
    rdData = '0;
    for (int p = 0; p < PIN_COUNT; p++) begin
      rdData[p*FIELD_STRIDE + DIR_BIT] = dirQ[p];
      rdData[p*FIELD_STRIDE + VAL_BIT] = valQ[p];
      rdData[p*FIELD_STRIDE + IN_BIT]  = inSync[p];
      rdData[p*FIELD_STRIDE + PUD_BIT] = pudQ[p];
    end
  end
endmodule

// File: rtl/gpio_pin_reg.sv
module gpio_pin_reg
  import gpio_pin_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sclOut,
  output logic              sdaOe,
  output logic              sdaOut,
  output logic              sclPullupDis,
  output logic              sdaPullupDis
);
  pinStrobe_t [PIN_COUNT-1:0] strobes;
  logic [PIN_COUNT-1:0] padOe;
  logic [PIN_COUNT-1:0] padOut;
  logic [PIN_COUNT-1:0] pudOut;

  gpio_pin_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .strobes (strobes)
  );

  gpio_pin_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .padIn   ({sdaIn, sclIn}),
    .padOe   (padOe),
    .padOut  (padOut),
    .pudOut  (pudOut),
    .rdData  (rdData)
  );

  assign sclOe        = padOe[0];
  assign sdaOe        = padOe[1];
  assign sclOut       = padOut[0];
  assign sdaOut       = padOut[1];
  assign sclPullupDis = pudOut[0];
  assign sdaPullupDis = pudOut[1];
endmodule

// File: rtl/gpio_pin_reg_checker.sv
module gpio_pin_reg_checker #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              sclIn,
  input logic              sdaIn,
  input logic              sclOe,
  input logic              sdaOe,
  input logic              sclPullupDis,
  input logic              sdaPullupDis
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R2
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || !wrData[1]) |=> rdData[0] == $past(rdData[0]));
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[9]) |=> rdData[8] == $past(wrData[8]));
  // R3
  a_r3_val_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || !wrData[11]) |=> rdData[10] == $past(rdData[10]));
  // R5
  a_r5_scl_oe: assert property (@(posedge clk) disable iff (!rstN)
    sclOe == (rdData[0] && !rdData[2]));
  a_r5_sda_oe: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe == (rdData[8] && !rdData[10]));
  // R8
  a_r8_pud_load: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (sclPullupDis == $past(wrData[5])) && (sdaPullupDis == $past(wrData[13])));

  // R6
  if (SYNC_STAGES == 2) begin : g_sync_chk
    a_r6_sync_lat: assert property (@(posedge clk) disable iff (!rstN)
      (cyc >= 2'd2) |-> (rdData[4] == $past(sclIn, 2)) && (rdData[12] == $past(sdaIn, 2)));
  end
endmodule

bind gpio_pin_reg gpio_pin_reg_checker #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdData       (rdData),
  .sclIn        (sclIn),
  .sdaIn        (sdaIn),
  .sclOe        (sclOe),
  .sdaOe        (sdaOe),
  .sclPullupDis (sclPullupDis),
  .sdaPullupDis (sdaPullupDis)
);

// File: tb/sim_gpio_pin_reg.sv
`timescale 1ns/1ps
module sim_gpio_pin_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        sclIn = 1'b1;
  logic        sdaIn = 1'b1;
  logic        sclOe, sclOut, sdaOe, sdaOut, sclPullupDis, sdaPullupDis;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  gpio_pin_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sclIn(sclIn), .sdaIn(sdaIn), .sclOe(sclOe), .sclOut(sclOut),
    .sdaOe(sdaOe), .sdaOut(sdaOut),
    .sclPullupDis(sclPullupDis), .sdaPullupDis(sdaPullupDis)
  );

  localparam logic [31:0] CMP_MASK = ~32'h0000_1010;

  typedef struct packed {
    logic [31:0] wr;
    logic [31:0] exp;
    logic [1:0]  oe;   // {sda, scl}
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_000B, 32'h0000_0001, 2'b01},  // R2 R3 clock driven low
    '{32'h0000_0A00, 32'h0000_0001, 2'b01},  // R4 data masks, same values
    '{32'h0000_0D00, 32'h0000_0401, 2'b01},  // R2 R3 dir unmasked, value masked
    '{32'h0000_0300, 32'h0000_0501, 2'b01},  // R9 dir-only to output, stored 1
    '{32'h0000_0800, 32'h0000_0101, 2'b11},  // R5 value 0 drives
    '{32'h0000_0002, 32'h0000_0100, 2'b10},  // R4 clock released only
    '{32'h0000_0025, 32'h0000_0120, 2'b10},  // R8 pud loads, unmasked fields hold
    '{32'h0000_0000, 32'h0000_0100, 2'b10},  // R8 pud cleared without mask
    '{32'h0000_2003, 32'h0000_2101, 2'b11},  // R9 clock dir-only, stored 0
    '{32'hFFFF_C0C0, 32'h0000_0101, 2'b11},  // R7 undefined bits ignored
    '{32'h0000_0F0F, 32'h0000_0505, 2'b00},  // R5 both output value 1
    '{32'h0000_0606, 32'h0000_0404, 2'b00},  // R9 release keeps value
    '{32'h0000_0101, 32'h0000_0404, 2'b00}   // R2 dir without mask
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd in reset", rdData, 32'h0);
    check("R1 pads in reset", {28'h0, sclOe, sdaOe, sclPullupDis, sdaPullupDis}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 rd after reset", rdData & CMP_MASK, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].wr);
      check($sformatf("R2/R3/R4/R7/R9 vec%0d rd", i), rdData & CMP_MASK, VECS[i].exp);
      check($sformatf("R5 vec%0d oe", i), {30'h0, sdaOe, sclOe}, {30'h0, VECS[i].oe});
      check($sformatf("R5 vec%0d out level", i), {30'h0, sdaOut, sclOut}, 32'h0);
      check($sformatf("R8 vec%0d pud", i), {30'h0, sdaPullupDis, sclPullupDis},
            {30'h0, VECS[i].exp[13], VECS[i].exp[5]});
    end

    // R10: write strobe low ignores data
    @(negedge clk);
    wrData = 32'h0000_2B2B;
    @(negedge clk);
    @(negedge clk);
    wrData = '0;
    check("R10 no strobe", rdData & CMP_MASK, 32'h0000_0404);

    // R6: input bits high after long idle, then two-flop latency
    check("R6 inputs idle high", rdData & 32'h0000_1010, 32'h0000_1010);
    sclIn = 1'b0;
    @(negedge clk);
    check("R6 scl after one edge", {31'h0, rdData[4]}, 32'h1);
    @(negedge clk);
    check("R6 scl after two edges", {31'h0, rdData[4]}, 32'h0);
    // sampling sequence: release data, then a write with no masks
    doWrite(32'h0000_0200);
    sdaIn = 1'b0;
    doWrite(32'h0000_0000);
    @(negedge clk);
    check("R6 sda sampled low", rdData & 32'h0000_1010, 32'h0000_0000);
    sclIn = 1'b1;
    sdaIn = 1'b1;

    // R1 reset mid-operation
    doWrite(32'h0000_2B2B);
    check("R4 both driven", {30'h0, sdaOe, sclOe}, 32'h3);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 reset mid-op rd", rdData, 32'h0);
    check("R1 reset mid-op oe", {30'h0, sdaOe, sclOe}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    summary();
  end
endmodule